// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Unit

This block sits beside a pair of serial channels, A and B, and turns their interrupt events into one interrupt request line. Each channel reports four kinds of event as one-cycle pulses: transmit buffer empty, a change on the external/status lines, a received character, and a receive error. The error pulse comes in two forms, parity and overrun/framing. Each channel has its own configuration byte. The byte holds enables for the external and transmit interrupts and a two-bit receive mode. Together these decide which events become pending causes.

A programmable 8-bit vector is written through channel B. When the status-affects-vector bit in channel B's configuration is set, bits 3..1 of the vector are replaced with a code for the highest-priority pending cause. Host commands clear each pending cause, either directly or by removing its source (loading transmit data, taking the received character). When an acknowledge is accepted, the vector is frozen and the request is held off until a return strobe arrives.

Top module: `dual_chan_irq_vec`

## Requirements
- R1: After reset, no cause is pending, `irq` and `pend` are 0, the vector reads 0x00 and both channels are armed for their first received character.
- R2: A transmit or external/status event sets its pending bit one cycle later, but only if configuration bit 1 (transmit) or bit 0 (external) is set. `cmd_tx_rst` or `tx_load` clears the transmit pending bit. `cmd_ext_rst` clears the external pending bit.
- R3: Configuration bits 4..3 select the receive mode: 0 gives no receive interrupts, 1 interrupts only on the first character after a re-arm, and 2 or 3 interrupt on every character. `cmd_rearm` re-arms the channel. `rx_take` clears the receive pending bit.
- R4: In modes 1 to 3, an overrun/framing error sets the special condition. A parity error sets the special condition in modes 1 and 2, but in mode 3 it counts as an ordinary received character. `cmd_err_rst` clears the special condition.
- R5: With channel B configuration bit 2 clear, the vector reads exactly as written. With it set, bits 3..1 carry a cause code: B transmit 0, B external 1, B receive 2, B special 3, and codes 4 to 7 for the same four causes on A. When nothing is pending the code is 3.
- R6: The vector code reports the highest-priority cause. From highest to lowest: A special, A receive, A transmit, A external, B special, B receive, B transmit, B external.
- R7: A vector write takes effect only when `wr_chan`=1 (channel B). A vector read (`rd_sel`=1) on channel A returns 0x00.
- R8: A status read (`rd_sel`=0) on channel A returns `pend` in bit 1 with all other bits 0. A status read on channel B always returns 0x00.
- R9: `pend` is high while any pending bit has its enable or receive mode still on. Clearing the enable masks that bit without erasing it.
- R10: `ack` while `irq` is high freezes the vector read value and drops `irq`. `reti` releases the freeze, after which `irq` again follows `pend`.
- R11: If a set event and a clearing command for the same cause arrive in the same cycle, the cause ends up pending.
- R12: Bit 2 of channel A's configuration has no effect on the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_a | input | 8 | Channel A interrupt configuration |
| cfg_b | input | 8 | Channel B interrupt configuration (bit 2: status affects vector) |
| ev_tx | input | 2 | Transmit buffer empty pulse (bit 0 A, bit 1 B) |
| ev_ext | input | 2 | External/status change pulse |
| ev_rx | input | 2 | Received character pulse |
| ev_perr | input | 2 | Parity error pulse |
| ev_ferr | input | 2 | Overrun or framing error pulse |
| cmd_ext_rst | input | 2 | Clear external/status pending |
| cmd_tx_rst | input | 2 | Clear transmit pending |
| cmd_err_rst | input | 2 | Clear special receive condition |
| cmd_rearm | input | 2 | Re-arm first-character receive interrupt |
| tx_load | input | 2 | Transmit data loaded (source of transmit cause removed) |
| rx_take | input | 2 | Received character taken (source of receive cause removed) |
| ack | input | 1 | Interrupt acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| wr_en | input | 1 | Vector write strobe |
| wr_chan | input | 1 | Channel of the write (0 A, 1 B) |
| wr_data | input | 8 | Vector write data |
| rd_chan | input | 1 | Channel of the read (0 A, 1 B) |
| rd_sel | input | 1 | Read select (0 status, 1 vector) |
| rd_data | output | 8 | Read value |
| irq | output | 1 | Interrupt request |
| pend | output | 1 | Global interrupt pending flag |

## Verification
Two things can land on the same edge: a new event for a cause, and the command or source removal that clears that same cause. The same goes for an acknowledge arriving while the cause mix is changing. The bench drives both collisions directly: a transmit event together with its reset command, and a receive error landing while the vector is frozen. It then checks the readback, and a long random phase fires events, commands, configuration changes and strobes in the same cycles. A behavioural model in the bench predicts `irq`, `pend` and the read value on every cycle. Under that model a collision always resolves in favour of the event, and a freeze holds the captured vector.

// File: rtl/dual_chan_irq_vec.sv
module dual_chan_irq_vec #(
  parameter logic [7:0] VEC_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_a,
  input  logic [7:0] cfg_b,
  input  logic [1:0] ev_tx,
  input  logic [1:0] ev_ext,
  input  logic [1:0] ev_rx,
  input  logic [1:0] ev_perr,
  input  logic [1:0] ev_ferr,
  input  logic [1:0] cmd_ext_rst,
  input  logic [1:0] cmd_tx_rst,
  input  logic [1:0] cmd_err_rst,
  input  logic [1:0] cmd_rearm,
  input  logic [1:0] tx_load,
  input  logic [1:0] rx_take,
  input  logic       ack,
  input  logic       reti,
  input  logic       wr_en,
  input  logic       wr_chan,
  input  logic [7:0] wr_data,
  input  logic       rd_chan,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       pend
);

  logic [7:0] cfg [2];
  assign cfg[0] = cfg_a;
  assign cfg[1] = cfg_b;

  logic [1:0] p_tx, p_ext, p_rx, p_spc;
  logic [1:0] a_tx, a_ext, a_rx, a_spc;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [1:0] mode;
    logic       rx_on, first, rx_set, spc_set;
    logic       t_q, e_q, r_q, s_q, arm_q;

    assign mode    = cfg[c][4:3];
    assign rx_on   = mode != 2'd0;
    assign first   = (mode == 2'd1) & arm_q;
    assign rx_set  = (ev_rx[c] & (first | mode[1])) | (ev_perr[c] & (mode == 2'd3));
    assign spc_set = rx_on & (ev_ferr[c] | (ev_perr[c] & (mode != 2'd3)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q   <= 1'b0;
        e_q   <= 1'b0;
        r_q   <= 1'b0;
        s_q   <= 1'b0;
        arm_q <= 1'b1;
      end else begin
        t_q   <= (ev_tx[c] & cfg[c][1]) | (t_q & ~(cmd_tx_rst[c] | tx_load[c]));
        e_q   <= (ev_ext[c] & cfg[c][0]) | (e_q & ~cmd_ext_rst[c]);
        r_q   <= rx_set | (r_q & ~rx_take[c]);
        s_q   <= spc_set | (s_q & ~cmd_err_rst[c]);
        arm_q <= cmd_rearm[c] | (arm_q & ~(ev_rx[c] & (mode == 2'd1)));
      end
    end

    assign p_tx[c]  = t_q;
    assign p_ext[c] = e_q;
    assign p_rx[c]  = r_q;
    assign p_spc[c] = s_q;
    assign a_tx[c]  = t_q & cfg[c][1];
    assign a_ext[c] = e_q & cfg[c][0];
    assign a_rx[c]  = r_q & rx_on;
    assign a_spc[c] = s_q & rx_on;
  end

  logic [2:0] code;
  always_comb begin
    if      (a_spc[0]) code = 3'd7;
    else if (a_rx[0])  code = 3'd6;
    else if (a_tx[0])  code = 3'd4;
    else if (a_ext[0]) code = 3'd5;
    else if (a_spc[1]) code = 3'd3;
    else if (a_rx[1])  code = 3'd2;
    else if (a_tx[1])  code = 3'd0;
    else if (a_ext[1]) code = 3'd1;
    else               code = 3'd3;
  end

  logic [7:0] vec_q, hold_q, vec_live;
  logic       in_svc;

  assign pend     = |{a_tx, a_ext, a_rx, a_spc};
  assign irq      = pend & ~in_svc;
  assign vec_live = cfg_b[2] ? {vec_q[7:4], code, vec_q[0]} : vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= VEC_INIT;
      hold_q <= VEC_INIT;
      in_svc <= 1'b0;
    end else begin
      if (wr_en && wr_chan) vec_q <= wr_data;
      if (reti) begin
        in_svc <= 1'b0;
      end else if (ack && irq) begin
        in_svc <= 1'b1;
        hold_q <= vec_live;
      end
    end
  end

  always_comb begin
    case ({rd_sel, rd_chan})
      2'b00:   rd_data = {6'd0, pend, 1'b0};
      2'b11:   rd_data = in_svc ? hold_q : vec_live;
      default: rd_data = 8'h00;
    endcase
  end

endmodule

module dual_chan_irq_vec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       pend,
  input logic       in_svc,
  input logic       rd_chan,
  input logic       rd_sel,
  input logic [7:0] rd_data,
  input logic       wr_en,
  input logic       wr_chan,
  input logic [7:0] vec_q,
  input logic [7:0] cfg_a,
  input logic [1:0] p_rx
);

  assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  assert_svc_holds_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc |-> !irq);

  assert_svc_vec_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc && $past(in_svc) && rd_chan && rd_sel && $past(rd_chan && rd_sel))
      |-> $stable(rd_data));

  assert_chan_b_status_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chan && !rd_sel) |-> (rd_data == 8'h00));

  assert_a_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_chan) |=> $stable(vec_q));

  assert_mode0_no_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_a[4:3] == 2'd0 && !p_rx[0]) |=> !p_rx[0]);

endmodule

bind dual_chan_irq_vec dual_chan_irq_vec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pend(pend), .in_svc(in_svc),
  .rd_chan(rd_chan), .rd_sel(rd_sel), .rd_data(rd_data), .wr_en(wr_en),
  .wr_chan(wr_chan), .vec_q(vec_q), .cfg_a(cfg_a), .p_rx(p_rx)
);

// File: tb/dual_chan_irq_vec_tb.sv
`timescale 1ns/100ps
module dual_chan_irq_vec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] cfg_a = 0, cfg_b = 0, wr_data = 0;
  logic [1:0] ev_tx = 0, ev_ext = 0, ev_rx = 0, ev_perr = 0, ev_ferr = 0;
  logic [1:0] cmd_ext_rst = 0, cmd_tx_rst = 0, cmd_err_rst = 0, cmd_rearm = 0;
  logic [1:0] tx_load = 0, rx_take = 0;
  logic ack = 0, reti = 0, wr_en = 0, wr_chan = 0, rd_chan = 0, rd_sel = 0;
  logic [7:0] rd_data;
  logic irq, pend;

  dual_chan_irq_vec dut_i (.*);

  int checks = 0, fails = 0;

  // behavioural reference model
  int m_tx[2], m_ext[2], m_rx[2], m_spc[2], m_arm[2];
  int m_vec, m_hold, m_svc;

  function automatic int mcfg(int ch);
    return ch == 0 ? int'(cfg_a) : int'(cfg_b);
  endfunction

  function automatic int mmode(int ch);
    return (mcfg(ch) >> 3) & 3;
  endfunction

  function automatic bit mact(int ch, int kind);
    case (kind)
      0: return m_tx[ch] != 0 && ((mcfg(ch) >> 1) & 1) != 0;
      1: return m_ext[ch] != 0 && (mcfg(ch) & 1) != 0;
      2: return m_rx[ch] != 0 && mmode(ch) != 0;
      default: return m_spc[ch] != 0 && mmode(ch) != 0;
    endcase
  endfunction

  function automatic bit mpend();
    for (int ch = 0; ch < 2; ch++)
      for (int k = 0; k < 4; k++)
        if (mact(ch, k)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int mcode();
    int order_k[4] = '{3, 2, 0, 1};
    for (int ch = 0; ch < 2; ch++)
      for (int i = 0; i < 4; i++)
        if (mact(ch, order_k[i])) return (ch == 0 ? 4 : 0) + order_k[i];
    return 3;
  endfunction

  function automatic int mlive();
    if (cfg_b[2]) return (m_vec & 8'hF1) | (mcode() << 1);
    return m_vec;
  endfunction

  function automatic int mread();
    if (!rd_sel) return rd_chan ? 0 : (mpend() ? 2 : 0);
    if (!rd_chan) return 0;
    return m_svc != 0 ? m_hold : mlive();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int ch = 0; ch < 2; ch++) begin
        m_tx[ch] = 0; m_ext[ch] = 0; m_rx[ch] = 0; m_spc[ch] = 0; m_arm[ch] = 1;
      end
      m_vec = 0; m_hold = 0; m_svc = 0;
    end else begin
      int lv;
      bit ir;
      int md;
      lv = mlive();
      ir = mpend() && m_svc == 0;
      for (int ch = 0; ch < 2; ch++) begin
        md = mmode(ch);
        if (ev_tx[ch] && ((mcfg(ch) >> 1) & 1)) m_tx[ch] = 1;
        else if (cmd_tx_rst[ch] || tx_load[ch]) m_tx[ch] = 0;
        if (ev_ext[ch] && (mcfg(ch) & 1)) m_ext[ch] = 1;
        else if (cmd_ext_rst[ch]) m_ext[ch] = 0;
        if ((ev_rx[ch] && ((md == 1 && m_arm[ch] != 0) || md >= 2)) || (ev_perr[ch] && md == 3))
          m_rx[ch] = 1;
        else if (rx_take[ch]) m_rx[ch] = 0;
        if (md != 0 && (ev_ferr[ch] || (ev_perr[ch] && md != 3))) m_spc[ch] = 1;
        else if (cmd_err_rst[ch]) m_spc[ch] = 0;
        if (cmd_rearm[ch]) m_arm[ch] = 1;
        else if (ev_rx[ch] && md == 1) m_arm[ch] = 0;
      end
      if (reti) m_svc = 0;
      else if (ack && ir) begin m_svc = 1; m_hold = lv; end
      if (wr_en && wr_chan) m_vec = wr_data;
    end
  end

  // cycle-by-cycle comparison, well clear of both edges
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      checks += 3;
      if (pend !== mpend()) begin
        fails++; $display("FAIL R9 pend: got %0d expected %0d", pend, mpend());
      end
      if (irq !== (mpend() && m_svc == 0)) begin
        fails++; $display("FAIL R10 irq: got %0d expected %0d", irq, mpend() && m_svc == 0);
      end
      if (rd_data !== 8'(mread())) begin
        fails++; $display("FAIL R5 rd_data: got %02h expected %02h", rd_data, mread());
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clr();
    ev_tx = 0; ev_ext = 0; ev_rx = 0; ev_perr = 0; ev_ferr = 0;
    cmd_ext_rst = 0; cmd_tx_rst = 0; cmd_err_rst = 0; cmd_rearm = 0;
    tx_load = 0; rx_take = 0; ack = 0; reti = 0; wr_en = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic rdv(int chan, int sel, output int v);
    rd_chan = chan[0]; rd_sel = sel[0];
    #1 v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    int v;
    do_reset();
    rdv(1, 1, v); chk("R1 vector after reset", v, 8'h00);
    chk("R1 irq after reset", irq, 0);
    chk("R1 pend after reset", pend, 0);

    wr_en = 1; wr_chan = 0; wr_data = 8'hA0; step();
    rdv(1, 1, v); chk("R7 write on A ignored", v, 8'h00);
    wr_en = 1; wr_chan = 1; wr_data = 8'hA5; step();
    rdv(1, 1, v); chk("R5 programmed vector", v, 8'hA5);
    rdv(0, 1, v); chk("R7 vector read on A", v, 8'h00);

    cfg_a = 8'h00; ev_tx = 2'b01; step();
    chk("R2 disabled tx ignored", pend, 0);
    cfg_a = 8'h0A; ev_tx = 2'b01; step();
    chk("R2 enabled tx pending", pend, 1);
    rdv(0, 0, v); chk("R8 status A", v, 8'h02);
    rdv(1, 0, v); chk("R8 status B", v, 8'h00);
    cfg_a = 8'h0E; #1;
    rdv(1, 1, v); chk("R12 A bit2 no effect", v, 8'hA5);
    cfg_a = 8'h0A; cfg_b = 8'h04; #1;
    rdv(1, 1, v); chk("R5 A tx code", v, 8'hA9);

    ev_ferr = 2'b01; step();
    rdv(1, 1, v); chk("R6 special above tx", v, 8'hAF);
    cmd_err_rst = 2'b01; step();
    rdv(1, 1, v); chk("R4 error reset", v, 8'hA9);

    ev_rx = 2'b01; step();
    rdv(1, 1, v); chk("R3 first char", v, 8'hAD);
    rx_take = 2'b01; step();
    ev_rx = 2'b01; step();
    rdv(1, 1, v); chk("R3 second char ignored", v, 8'hA9);
    cmd_rearm = 2'b01; step();
    ev_rx = 2'b01; step();
    rdv(1, 1, v); chk("R3 after rearm", v, 8'hAD);
    rx_take = 2'b01; step();

    cfg_b = 8'h06; ev_tx = 2'b10; step();
    rdv(1, 1, v); chk("R6 A above B", v, 8'hA9);
    cmd_tx_rst = 2'b01; step();
    rdv(1, 1, v); chk("R6 B tx code", v, 8'hA1);
    cmd_tx_rst = 2'b10; step();
    rdv(1, 1, v); chk("R5 none pending code", v, 8'hA7);
    chk("R2 tx reset clears", pend, 0);

    ev_tx = 2'b01; cmd_tx_rst = 2'b01; step();
    rdv(1, 1, v); chk("R11 set wins", v, 8'hA9);

    cfg_a = 8'h08; #1; chk("R9 masked", pend, 0);
    cfg_a = 8'h0A; #1; chk("R9 unmasked", pend, 1);

    ack = 1; step();
    chk("R10 irq held", irq, 0);
    ev_ferr = 2'b01; step();
    rdv(1, 1, v); chk("R10 frozen vector", v, 8'hA9);
    reti = 1; step();
    chk("R10 irq after reti", irq, 1);
    rdv(1, 1, v); chk("R10 live after reti", v, 8'hAF);

    cmd_err_rst = 2'b01; cfg_a = 8'h1A; step();
    ev_perr = 2'b01; step();
    rdv(1, 1, v); chk("R4 parity in mode3", v, 8'hAD);
    rx_take = 2'b01; cfg_a = 8'h12; step();
    ev_perr = 2'b01; step();
    rdv(1, 1, v); chk("R4 parity in mode2", v, 8'hAF);

    do_reset();
    for (int i = 0; i < 4000; i++) begin
      ev_tx = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      ev_ext = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      ev_rx = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      ev_perr = 2'($urandom_range(0, 3) & $urandom_range(0, 3) & $urandom_range(0, 3));
      ev_ferr = 2'($urandom_range(0, 3) & $urandom_range(0, 3) & $urandom_range(0, 3));
      cmd_ext_rst = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      cmd_tx_rst = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      cmd_err_rst = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      cmd_rearm = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      tx_load = 2'($urandom_range(0, 3) & $urandom_range(0, 3) & $urandom_range(0, 3));
      rx_take = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      ack = ($urandom_range(0, 5) == 0);
      reti = ($urandom_range(0, 7) == 0);
      wr_en = ($urandom_range(0, 15) == 0);
      wr_chan = 1'($urandom_range(0, 1));
      wr_data = 8'($urandom);
      rd_chan = 1'($urandom_range(0, 1));
      rd_sel = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 31) == 0) cfg_a = 8'($urandom);
      if ($urandom_range(0, 31) == 0) cfg_b = 8'($urandom);
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule